// File: doc/BRIEF.md
# Booth-Selecting Seven-to-Two Column Compressor Slice

This block is one tile of the carry-save reduction array of a wide parallel multiplier. It spans a fixed group of adjacent bit columns (four by default). Inside each column, seven radix-4 Booth selectors form seven partial-product bits from the multiplicand and the Booth control of their row. Two sub-blocks then reduce those seven bits to two: four selectors feed a 4-2 compressor, three selectors feed a full adder, and a second 4-2 compressor merges the two results into one sum bit and one carry bit for the column.

Carries that move one column to the left are chained inside the slice. The carries that leave the top column come out on a link output, and the carries that enter the bottom column come in on a link input. Slices can therefore be placed side by side along a row of columns and stacked to reduce taller columns; four of them reduce a 28-bit column. The block is purely combinational. The Booth encoder, the final carry-propagate adder and the wiring of the full array belong to other blocks.

Top module: `cmp72_slice`

## Requirements
- R1: The partial-product bit of row r in column k is ((one_r & a_j) | (two_r & a_j-1)) ^ neg_r, where a_j is `mcand_win[r][k+1]` and a_j-1 is `mcand_win[r][k]`. At most one of `sel_one[r]` and `sel_two[r]` is high.
- R2: A row with both `sel_one` and `sel_two` low adds the value of its `sel_neg` bit in every column of the slice.
- R3: For every input, the slice value sum over k of 2^k·(`sum_o[k]` + 2·`carry_o[k]`) plus 2^COLS times the number of ones in `lat_out` equals the sum over k of 2^k times the number of set partial-product bits in column k, plus the number of ones in `lat_in`.
- R4: Each column individually conserves weight: its seven partial-product bits plus its four incoming link carries equal its sum bit plus twice its carry bit plus twice the count of its four outgoing link carries.
- R5: `lat_out` does not depend on `lat_in`. No carry ripples through the slice from its lowest column to its highest.
- R6: Changing `lat_in` can alter the outputs of columns 0, 1 and 2 only. `sum_o[k]` and `carry_o[k]` for k ≥ 3 do not depend on `lat_in`.
- R7: With every selector control low and `lat_in` zero, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_one | input | 7 | Per-row Booth control: select a_j |
| sel_two | input | 7 | Per-row Booth control: select a_j-1 (doubled multiplicand) |
| sel_neg | input | 7 | Per-row Booth control: invert the selected bit |
| mcand_win | input | 7×(COLS+1) | Per-row multiplicand window; bit i of row r feeds columns i and i-1 |
| lat_in | input | 4 | Link carries entering the lowest column, each of weight 1 there |
| sum_o | output | COLS | Sum bit of each column |
| carry_o | output | COLS | Carry bit of each column, weight 2^(k+1) |
| lat_out | output | 4 | Link carries leaving the highest column, each of weight 2^COLS |

## Verification
The bench isolates each Booth row in turn with only `one` or only `two` set. A selector that swapped a_j and a_j-1, or mapped the window off by a column, would give a slice value shifted by a factor of two. Rows with zero control and `neg` set check that the inversion still applies to the constant, which a design gating `neg` by the selection would lose. Random legal inputs and an exhaustive sweep of `lat_in` check weight conservation and that the link carries stay local. A compressor whose lateral carry depended on its own carry input would ripple, and the change would show up in `lat_out` or in column 3.

// File: rtl/cmp72_pkg.sv
package cmp72_pkg;

    // Number of Booth rows reduced by one column of the slice.
    localparam int PP_ROWS    = 7;
    // Rows handled by the four-input sub-block and by the three-input sub-block.
    localparam int UPPER_ROWS = 4;
    localparam int LOWER_ROWS = PP_ROWS - UPPER_ROWS;
    // Carries passed from one column to the next.
    localparam int LINK_W     = 4;

    // One-hot Booth control of one row (one and two never both high).
    typedef struct packed {
        logic one;
        logic two;
        logic neg;
    } booth_ctl_t;

    // Carries passed from column k to column k+1, all of weight 2 at column k.
    typedef struct packed {
        logic cout_a;   // lateral carry of the upper 4-2 compressor
        logic carry_a;  // carry of the upper 4-2 compressor
        logic carry_b;  // carry of the full adder
        logic cout_f;   // lateral carry of the merging 4-2 compressor
    } col_link_t;

    // Radix-4 Booth bit selection.
    function automatic logic booth_pick(booth_ctl_t c, logic a_hi, logic a_lo);
        return ((c.one & a_hi) | (c.two & a_lo)) ^ c.neg;
    endfunction

    // Count of set bits in a link bundle.
    function automatic int unsigned link_ones(col_link_t l);
        return int'(l.cout_a) + int'(l.carry_a) + int'(l.carry_b) + int'(l.cout_f);
    endfunction

endpackage

// File: rtl/cmp72_fa.sv
module cmp72_fa (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic s,
    output logic co
);
    logic ab_x;

    always_comb begin
        ab_x = a ^ b;
        s    = ab_x ^ c;
        co   = (a & b) | (ab_x & c);
    end

    // R4
    always_comb begin
        if (!$isunknown({a, b, c})) begin
            fa_weight_chk: assert ((int'(a) + int'(b) + int'(c)) == (int'(s) + 2 * int'(co)))
                else $error("full adder loses weight");
        end
    end
endmodule

// File: rtl/cmp72_c42.sv
module cmp72_c42 (
    input  logic [3:0] x,
    input  logic       cin,
    output logic       s,
    output logic       c,
    output logic       co
);
    logic s_mid;

    // First stage: three inputs, lateral carry independent of cin.
    cmp72_fa u_fa0 (
        .a  (x[0]),
        .b  (x[1]),
        .c  (x[2]),
        .s  (s_mid),
        .co (co)
    );

    // Second stage: merges the fourth input and the lateral carry-in.
    cmp72_fa u_fa1 (
        .a  (s_mid),
        .b  (x[3]),
        .c  (cin),
        .s  (s),
        .co (c)
    );

    // R4
    always_comb begin
        if (!$isunknown({x, cin})) begin
            c42_weight_chk: assert ((int'($countones(x)) + int'(cin)) ==
                                    (int'(s) + 2 * int'(c) + 2 * int'(co)))
                else $error("4-2 compressor loses weight");
        end
    end
endmodule

// File: rtl/cmp72_sel_group.sv
module cmp72_sel_group
    import cmp72_pkg::*;
#(
    parameter int N = 4
) (
    input  booth_ctl_t [N-1:0] ctl,
    input  logic       [N-1:0] a_hi,
    input  logic       [N-1:0] a_lo,
    output logic       [N-1:0] pp
);
    for (genvar i = 0; i < N; i++) begin : g_sel
        always_comb pp[i] = booth_pick(ctl[i], a_hi[i], a_lo[i]);

        // R2
        always_comb begin
            if (!$isunknown({ctl[i], a_hi[i], a_lo[i]}) && !ctl[i].one && !ctl[i].two) begin
                zero_sel_chk: assert (pp[i] == ctl[i].neg)
                    else $error("idle selector does not follow neg");
            end
        end

        // R1
        always_comb begin
            if (!$isunknown({ctl[i].one, ctl[i].two})) begin
                ctl_onehot_chk: assert (!(ctl[i].one && ctl[i].two))
                    else $error("Booth control not one-hot");
            end
        end
    end
endmodule

// File: rtl/cmp72_column.sv
module cmp72_column
    import cmp72_pkg::*;
(
    input  booth_ctl_t [PP_ROWS-1:0] ctl,
    input  logic       [PP_ROWS-1:0] a_hi,
    input  logic       [PP_ROWS-1:0] a_lo,
    input  col_link_t                link_i,
    output col_link_t                link_o,
    output logic                     sum_o,
    output logic                     carry_o
);
    logic [PP_ROWS-1:0] pp;
    logic sum_a, car_a, co_a;
    logic sum_b, car_b;
    logic co_f;

    // Four-input sub-block: selectors and 4-2 compressor.
    cmp72_sel_group #(.N(UPPER_ROWS)) u_sel_up (
        .ctl  (ctl[UPPER_ROWS-1:0]),
        .a_hi (a_hi[UPPER_ROWS-1:0]),
        .a_lo (a_lo[UPPER_ROWS-1:0]),
        .pp   (pp[UPPER_ROWS-1:0])
    );

    cmp72_c42 u_c42_up (
        .x   (pp[UPPER_ROWS-1:0]),
        .cin (link_i.cout_a),
        .s   (sum_a),
        .c   (car_a),
        .co  (co_a)
    );

    // Three-input sub-block: selectors and full adder.
    cmp72_sel_group #(.N(LOWER_ROWS)) u_sel_lo (
        .ctl  (ctl[PP_ROWS-1:UPPER_ROWS]),
        .a_hi (a_hi[PP_ROWS-1:UPPER_ROWS]),
        .a_lo (a_lo[PP_ROWS-1:UPPER_ROWS]),
        .pp   (pp[PP_ROWS-1:UPPER_ROWS])
    );

    cmp72_fa u_fa_lo (
        .a  (pp[UPPER_ROWS]),
        .b  (pp[UPPER_ROWS+1]),
        .c  (pp[UPPER_ROWS+2]),
        .s  (sum_b),
        .co (car_b)
    );

    // Merging 4-2 compressor: own sums plus carries from the column below.
    cmp72_c42 u_c42_mrg (
        .x   ({sum_a, sum_b, link_i.carry_a, link_i.carry_b}),
        .cin (link_i.cout_f),
        .s   (sum_o),
        .c   (carry_o),
        .co  (co_f)
    );

    always_comb begin
        link_o.cout_a  = co_a;
        link_o.carry_a = car_a;
        link_o.carry_b = car_b;
        link_o.cout_f  = co_f;
    end

    // R4
    always_comb begin
        if (!$isunknown({pp, link_i})) begin
            col_weight_chk: assert ((int'($countones(pp)) + int'(link_ones(link_i))) ==
                                    (int'(sum_o) + 2 * int'(carry_o) + 2 * int'(link_ones(link_o))))
                else $error("column weight not conserved");
        end
    end
endmodule

// File: rtl/cmp72_slice.sv
module cmp72_slice
    import cmp72_pkg::*;
#(
    parameter int COLS = 4
) (
    input  logic [PP_ROWS-1:0]         sel_one,
    input  logic [PP_ROWS-1:0]         sel_two,
    input  logic [PP_ROWS-1:0]         sel_neg,
    input  logic [PP_ROWS-1:0][COLS:0] mcand_win,
    input  logic [LINK_W-1:0]          lat_in,
    output logic [COLS-1:0]            sum_o,
    output logic [COLS-1:0]            carry_o,
    output logic [LINK_W-1:0]          lat_out
);
    localparam int WIN_W = COLS + 1;

    booth_ctl_t [PP_ROWS-1:0] ctl;
    col_link_t                chain [COLS+1];

    always_comb begin
        for (int r = 0; r < PP_ROWS; r++) begin
            ctl[r].one = sel_one[r];
            ctl[r].two = sel_two[r];
            ctl[r].neg = sel_neg[r];
        end
    end

    assign chain[0] = col_link_t'(lat_in);
    assign lat_out  = LINK_W'(chain[COLS]);

    for (genvar k = 0; k < COLS; k++) begin : g_col
        logic [PP_ROWS-1:0] a_hi_k;
        logic [PP_ROWS-1:0] a_lo_k;

        // Column k sees a_j at window bit k+1 and a_j-1 at window bit k.
        always_comb begin
            for (int r = 0; r < PP_ROWS; r++) begin
                a_hi_k[r] = mcand_win[r][k+1];
                a_lo_k[r] = mcand_win[r][k];
            end
        end

        cmp72_column u_col (
            .ctl     (ctl),
            .a_hi    (a_hi_k),
            .a_lo    (a_lo_k),
            .link_i  (chain[k]),
            .link_o  (chain[k+1]),
            .sum_o   (sum_o[k]),
            .carry_o (carry_o[k])
        );
    end

    // R3: slice-level weight, built from ports only.
    int unsigned in_w;
    int unsigned out_w;
    always_comb begin
        in_w  = int'($countones(lat_in));
        out_w = int'($countones(lat_out)) << COLS;
        for (int k = 0; k < COLS; k++) begin
            for (int r = 0; r < PP_ROWS; r++) begin
                in_w = in_w + (int'(((sel_one[r] & mcand_win[r][k+1]) |
                                     (sel_two[r] & mcand_win[r][k])) ^ sel_neg[r]) << k);
            end
            out_w = out_w + ((int'(sum_o[k]) + 2 * int'(carry_o[k])) << k);
        end
    end

    // R3
    always_comb begin
        if (!$isunknown({sel_one, sel_two, sel_neg, mcand_win, lat_in})) begin
            slice_weight_chk: assert (in_w == out_w)
                else $error("slice weight not conserved");
        end
    end

    // R7
    always_comb begin
        if (!$isunknown({sel_one, sel_two, sel_neg, lat_in}) &&
            (sel_one == '0) && (sel_two == '0) && (sel_neg == '0) && (lat_in == '0)) begin
            idle_zero_chk: assert ((sum_o == '0) && (carry_o == '0) && (lat_out == '0))
                else $error("idle slice drives nonzero output");
        end
    end

    if (WIN_W < 2) begin : g_bad_cols
        initial $error("COLS must be at least 1");
    end
endmodule

// File: tb/sim_cmp72_slice.sv
module sim_cmp72_slice;
    localparam int CLK_PERIOD = 10;
    localparam int COLS = 4;
    localparam int ROWS = 7;
    localparam int LW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [ROWS-1:0]         sel_one, sel_two, sel_neg;
    logic [ROWS-1:0][COLS:0] mcand_win;
    logic [LW-1:0]           lat_in;
    logic [COLS-1:0]         sum_o, carry_o;
    logic [LW-1:0]           lat_out;

    int n_cmp = 0;
    int n_bad = 0;

    cmp72_slice #(.COLS(COLS)) u0 (
        .sel_one   (sel_one),
        .sel_two   (sel_two),
        .sel_neg   (sel_neg),
        .mcand_win (mcand_win),
        .lat_in    (lat_in),
        .sum_o     (sum_o),
        .carry_o   (carry_o),
        .lat_out   (lat_out)
    );

    // Expected slice value from the R1 selector rule and R3 weights.
    function automatic int exp_val();
        int t = $countones(lat_in);
        for (int k = 0; k < COLS; k++) begin
            for (int r = 0; r < ROWS; r++) begin
                logic pp;
                pp = ((sel_one[r] & mcand_win[r][k+1]) | (sel_two[r] & mcand_win[r][k])) ^ sel_neg[r];
                t += int'(pp) << k;
            end
        end
        return t;
    endfunction

    function automatic int got_val();
        int t = $countones(lat_out) << COLS;
        for (int k = 0; k < COLS; k++) t += (int'(sum_o[k]) + 2 * int'(carry_o[k])) << k;
        return t;
    endfunction

    task automatic check_int(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        sel_one = '0; sel_two = '0; sel_neg = '0; mcand_win = '0; lat_in = '0;
    endtask

    // Legal random control: none, one or two; random neg.
    task automatic rand_inputs();
        for (int r = 0; r < ROWS; r++) begin
            int pick = $urandom_range(2);
            sel_one[r] = (pick == 1);
            sel_two[r] = (pick == 2);
            sel_neg[r] = 1'($urandom_range(1));
            mcand_win[r] = (COLS+1)'($urandom);
        end
        lat_in = LW'($urandom);
    endtask

    task automatic t_idle();
        clear_inputs();
        mcand_win = {ROWS{5'b10110}};
        settle();
        // R7
        check_int("R7 idle sum", int'(sum_o), 0);
        check_int("R7 idle carry", int'(carry_o), 0);
        check_int("R7 idle lat_out", int'(lat_out), 0);
    endtask

    task automatic t_single_rows();
        for (int r = 0; r < ROWS; r++) begin
            for (int m = 0; m < 2; m++) begin
                clear_inputs();
                mcand_win[r] = 5'b01101;
                if (m == 0) sel_one[r] = 1'b1; else sel_two[r] = 1'b1;
                settle();
                // R1: one picks window bits 4..1, two picks bits 3..0
                check_int(m == 0 ? "R1 row one" : "R1 row two", got_val(),
                          m == 0 ? 6 : 13);
            end
        end
    endtask

    task automatic t_neg_idle();
        clear_inputs();
        sel_neg = 7'b1010011;
        mcand_win = {ROWS{5'b11111}};
        settle();
        // R2: four idle rows with neg, each contributing 1 in all four columns
        check_int("R2 neg idle", got_val(), 4 * 15);
        clear_inputs();
        sel_neg = '1;
        sel_one = '1;
        mcand_win = {ROWS{5'b11111}};
        settle();
        // R1 negated ones cancel to zero
        check_int("R1 neg of ones", got_val(), 0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 600; i++) begin
            rand_inputs();
            settle();
            // R3 (slice total) and R4 (per column, which sums to it)
            check_int("R3 R4 random weight", got_val(), exp_val());
        end
    endtask

    task automatic t_link_locality();
        for (int n = 0; n < 20; n++) begin
            int base_lat, base_hi;
            rand_inputs();
            lat_in = '0;
            settle();
            base_lat = int'(lat_out);
            base_hi  = {sum_o[3], carry_o[3]};
            for (int v = 1; v < 16; v++) begin
                lat_in = LW'(v);
                settle();
                // R5
                check_int("R5 lat_out fixed", int'(lat_out), base_lat);
                // R6
                check_int("R6 column 3 fixed", int'({sum_o[3], carry_o[3]}), base_hi);
                check_int("R3 link weight", got_val(), exp_val());
            end
        end
    endtask

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_single_rows();
        t_neg_idle();
        t_random();
        t_link_locality();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R3: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule